// File: doc/BRIEF.md
# Per-Tile Palette Attribute Substitution

This block sits beside the video renderer's memory port and watches every fetch. When a rendering fetch reads a name-table byte, the block keeps the low ten bits of that address as the tile offset. When the next rendering fetch reads the attribute area, the block can answer it from its own storage instead of from video memory. The answer gives each tile its own 2-bit palette, not the usual shared palette for a 2x2 tile group.

Two stores of 1024 palette entries each hold this data, and the CPU fills them through an upper write window. A control register, also written by the CPU, selects the name-table mirroring mode, turns the substitution on, and grants write access to work RAM. The mirroring mode also decides which store answers a given attribute fetch. When the substitution does not apply, the normal video-memory byte passes through. Every fetch is answered one clock later, whether it comes from the stores or passes through.

Top module: `exattr_top`

## Requirements
- R1: After synchronous reset: `vid_rvalid` is 0, `vid_rdata` is 0x00, `mirror_mode` is 0 (vertical), `ext_attr_en` is 0 and `wram_wr_en` is 0. The latched tile offset is 0.
- R2: A CPU write whose address matches 0x800A under mask 0xC00F (A15=1, A14=0, A3..A0=0xA) loads the control register. Its outputs change on the next clock: data bits 1:0 give `mirror_mode` (0 vertical, 1 horizontal, 2 single A, 3 single B), bit 2 gives `ext_attr_en` and bit 3 gives `wram_wr_en`. No other CPU write changes these outputs.
- R3: A CPU write with A15=A14=1 stores data bits 1:0 into store A10, at entry A9..A0. The 2K window therefore repeats throughout 0xC000-0xFFFF.
- R4: A rendering fetch is a name-table fetch when its 14-bit address is at least 0x2000 and its low ten bits are below 0x3C0. Such a fetch latches its low ten bits as the tile offset. The offset holds through every other fetch and resets to 0.
- R5: A rendering fetch is an attribute fetch when its address is at least 0x2000 and its low ten bits are 0x3C0 or above. If `ext_attr_en` is 1, `vid_rdata` one clock later holds the selected store entry at the tile offset, repeated into all four 2-bit fields. `vid_rvalid` is 1 exactly one clock after each `vid_valid`.
- R6: Store choice for an attribute fetch depends on the mirroring mode. Single A uses store 0 and single B uses store 1. Vertical uses fetch address bit 10 and horizontal uses fetch address bit 11.
- R7: Every other fetch returns `vid_mem_data` unchanged one clock later. This covers non-rendering fetches, fetches below 0x2000, name-table fetches, and attribute fetches while `ext_attr_en` is 0.
- R8: If a CPU store write and an attribute fetch reading the same entry fall in the same clock, the fetch returns the entry's previous contents. Later fetches see the new value.
- R9: If a control write and an attribute fetch fall in the same clock, the fetch is judged with the control settings from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_we | input | 1 | CPU write strobe |
| cpu_addr | input | 16 | CPU write address |
| cpu_wdata | input | 8 | CPU write data |
| vid_valid | input | 1 | Video fetch present this cycle |
| vid_render | input | 1 | Fetch belongs to rendering |
| vid_addr | input | 14 | Video fetch address |
| vid_mem_data | input | 8 | Byte read from video memory for this fetch |
| vid_rvalid | output | 1 | Answer for the fetch of the previous cycle |
| vid_rdata | output | 8 | Answer byte |
| mirror_mode | output | 2 | Selected name-table mirroring mode |
| ext_attr_en | output | 1 | Per-tile palette substitution enabled |
| wram_wr_en | output | 1 | Work RAM writes allowed |

## Verification
Two pairs of functions can land in the same clock. A CPU write to a palette entry can meet an attribute fetch that reads that entry, and a control-register write can meet an attribute fetch. The bench provokes each pair by driving the write and the fetch together in one cycle. It then expects the old store value (R8) or the old mode and enable (R9), and checks the following fetch for the updated effect. A reference model in the bench holds the stores, the control fields and the tile offset. It predicts every answer byte into a scoreboard queue, and a monitor compares each answer as it appears.

// File: rtl/exattr_pkg.sv
package exattr_pkg;

  localparam int BYTE_W = 8;
  localparam int PAL_W  = 2;

  typedef enum logic [1:0] {
    MIR_VERT  = 2'd0,
    MIR_HORZ  = 2'd1,
    MIR_ONE_A = 2'd2,
    MIR_ONE_B = 2'd3
  } mirror_e;

  // Repeat one palette code into every field of an attribute byte, so the
  // renderer's quadrant shift always lands on the same palette.
  function automatic logic [BYTE_W-1:0] fan_palette(input logic [PAL_W-1:0] code);
    return {(BYTE_W/PAL_W){code}};
  endfunction

endpackage

// File: rtl/exattr_ctrl_reg.sv
module exattr_ctrl_reg
  import exattr_pkg::*;
#(
  parameter int          CPU_AW     = 16,
  parameter int          DW         = 8,
  parameter logic [15:0] CTRL_MASK  = 16'hC00F,
  parameter logic [15:0] CTRL_MATCH = 16'h800A
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cpu_we,
  input  logic [CPU_AW-1:0] cpu_addr,
  input  logic [DW-1:0] cpu_wdata,
  output mirror_e       mode,
  output logic          ext_en,
  output logic          wram_we
);

  localparam int MODE_LSB = 0;
  localparam int EXT_BIT  = 2;
  localparam int WRAM_BIT = 3;

  logic          hit;
  logic [DW-1:0] ctrl_q;

  assign hit = cpu_we && ((cpu_addr & CPU_AW'(CTRL_MASK)) == CPU_AW'(CTRL_MATCH));

  always_ff @(posedge clk) begin
    if (rst)      ctrl_q <= '0;
    else if (hit) ctrl_q <= cpu_wdata;
  end

  assign mode    = mirror_e'(ctrl_q[MODE_LSB +: 2]);
  assign ext_en  = ctrl_q[EXT_BIT];
  assign wram_we = ctrl_q[WRAM_BIT];

  assert_ctrl_load_R2: assert property (@(posedge clk) disable iff (rst)
    (cpu_we && ((cpu_addr & CPU_AW'(CTRL_MASK)) == CPU_AW'(CTRL_MATCH)))
      |=> ({wram_we, ext_en, mode} == $past(cpu_wdata[3:0])));

  assert_ctrl_keep_R2: assert property (@(posedge clk) disable iff (rst)
    !(cpu_we && ((cpu_addr & CPU_AW'(CTRL_MASK)) == CPU_AW'(CTRL_MATCH)))
      |=> $stable({wram_we, ext_en, mode}));

endmodule

// File: rtl/exattr_store.sv
module exattr_store #(
  parameter int DEPTH = 1024,
  parameter int W     = 2,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);

  logic [W-1:0] mem [DEPTH];

  // Read-first single clock RAM: a write and a read of one entry in the
  // same cycle return the entry's old contents.
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/exattr_fetch_snoop.sv
module exattr_fetch_snoop
  import exattr_pkg::*;
#(
  parameter int          VID_AW     = 14,
  parameter int          DW         = 8,
  parameter int          OFFS_W     = 10,
  parameter int          NUM_STORES = 2,
  parameter int          PW         = 2,
  parameter logic [13:0] NT_BASE    = 14'h2000,
  parameter logic [9:0]  ATTR_START = 10'h3C0
) (
  input  logic                           clk,
  input  logic                           rst,
  input  logic                           vid_valid,
  input  logic                           vid_render,
  input  logic [VID_AW-1:0]              vid_addr,
  input  logic [DW-1:0]                  vid_mem_data,
  input  mirror_e                        mode,
  input  logic                           ext_en,
  input  logic [NUM_STORES-1:0][PW-1:0]  store_q,
  output logic [OFFS_W-1:0]              rd_offset,
  output logic                           vid_rvalid,
  output logic [DW-1:0]                  vid_rdata
);

  localparam int BANK_W = (NUM_STORES > 1) ? $clog2(NUM_STORES) : 1;

  logic              in_table, attr_area, nt_hit, at_hit;
  logic [BANK_W-1:0] bank_sel;

  logic [OFFS_W-1:0] offset_q;
  logic              rvalid_q, use_store_q;
  logic [BANK_W-1:0] bank_q;
  logic [DW-1:0]     pass_q;

  assign in_table  = (vid_addr >= VID_AW'(NT_BASE));
  assign attr_area = (vid_addr[OFFS_W-1:0] >= ATTR_START);
  assign nt_hit    = vid_valid && vid_render && in_table && !attr_area;
  assign at_hit    = vid_valid && vid_render && in_table && attr_area;

  always_comb begin
    unique case (mode)
      MIR_VERT:  bank_sel = BANK_W'(vid_addr[OFFS_W]);
      MIR_HORZ:  bank_sel = BANK_W'(vid_addr[OFFS_W+1]);
      MIR_ONE_A: bank_sel = BANK_W'(0);
      default:   bank_sel = BANK_W'(1);
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      offset_q    <= '0;
      rvalid_q    <= 1'b0;
      use_store_q <= 1'b0;
      bank_q      <= '0;
      pass_q      <= '0;
    end else begin
      if (nt_hit) offset_q <= vid_addr[OFFS_W-1:0];
      rvalid_q    <= vid_valid;
      use_store_q <= at_hit && ext_en;
      bank_q      <= bank_sel;
      pass_q      <= vid_mem_data;
    end
  end

  assign rd_offset  = offset_q;
  assign vid_rvalid = rvalid_q;
  assign vid_rdata  = use_store_q ? DW'(fan_palette(store_q[bank_q])) : pass_q;

  assert_offset_load_R4: assert property (@(posedge clk) disable iff (rst)
    (vid_valid && vid_render && in_table && !attr_area)
      |=> (rd_offset == $past(vid_addr[OFFS_W-1:0])));

  assert_offset_hold_R4: assert property (@(posedge clk) disable iff (rst)
    !(vid_valid && vid_render && in_table && !attr_area) |=> $stable(rd_offset));

  assert_answer_valid_R5: assert property (@(posedge clk) disable iff (rst)
    vid_valid |=> vid_rvalid);

  assert_no_spurious_valid_R5: assert property (@(posedge clk) disable iff (rst)
    !vid_valid |=> !vid_rvalid);

  assert_pass_disabled_R7: assert property (@(posedge clk) disable iff (rst)
    (vid_valid && !ext_en) |=> (vid_rdata == $past(vid_mem_data)));

  assert_pass_nonrender_R7: assert property (@(posedge clk) disable iff (rst)
    (vid_valid && !vid_render) |=> (vid_rdata == $past(vid_mem_data)));

endmodule

// File: rtl/exattr_top.sv
module exattr_top
  import exattr_pkg::*;
#(
  parameter int          CPU_AW      = 16,
  parameter int          VID_AW      = 14,
  parameter int          DW          = BYTE_W,
  parameter int          PW          = PAL_W,
  parameter int          NUM_STORES  = 2,
  parameter int          STORE_DEPTH = 1024,
  parameter logic [15:0] STORE_MASK  = 16'hC000,
  parameter logic [15:0] STORE_MATCH = 16'hC000,
  parameter logic [15:0] CTRL_MASK   = 16'hC00F,
  parameter logic [15:0] CTRL_MATCH  = 16'h800A
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_we,
  input  logic [CPU_AW-1:0] cpu_addr,
  input  logic [DW-1:0]     cpu_wdata,
  input  logic              vid_valid,
  input  logic              vid_render,
  input  logic [VID_AW-1:0] vid_addr,
  input  logic [DW-1:0]     vid_mem_data,
  output logic              vid_rvalid,
  output logic [DW-1:0]     vid_rdata,
  output logic [1:0]        mirror_mode,
  output logic              ext_attr_en,
  output logic              wram_wr_en
);

  localparam int OFFS_W = $clog2(STORE_DEPTH);
  localparam int BANK_W = (NUM_STORES > 1) ? $clog2(NUM_STORES) : 1;

  mirror_e                       mode;
  logic                          store_hit;
  logic [BANK_W-1:0]             wr_bank;
  logic [OFFS_W-1:0]             rd_offset;
  logic [NUM_STORES-1:0][PW-1:0] store_q;

  exattr_ctrl_reg #(
    .CPU_AW     (CPU_AW),
    .DW         (DW),
    .CTRL_MASK  (CTRL_MASK),
    .CTRL_MATCH (CTRL_MATCH)
  ) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .cpu_we    (cpu_we),
    .cpu_addr  (cpu_addr),
    .cpu_wdata (cpu_wdata),
    .mode      (mode),
    .ext_en    (ext_attr_en),
    .wram_we   (wram_wr_en)
  );

  assign mirror_mode = mode;

  assign store_hit = cpu_we && ((cpu_addr & CPU_AW'(STORE_MASK)) == CPU_AW'(STORE_MATCH));
  assign wr_bank   = cpu_addr[OFFS_W +: BANK_W];

  for (genvar g = 0; g < NUM_STORES; g++) begin : g_store
    exattr_store #(
      .DEPTH (STORE_DEPTH),
      .W     (PW)
    ) u_store (
      .clk   (clk),
      .we    (store_hit && (wr_bank == BANK_W'(g))),
      .waddr (cpu_addr[OFFS_W-1:0]),
      .wdata (cpu_wdata[PW-1:0]),
      .raddr (rd_offset),
      .rdata (store_q[g])
    );
  end

  exattr_fetch_snoop #(
    .VID_AW     (VID_AW),
    .DW         (DW),
    .OFFS_W     (OFFS_W),
    .NUM_STORES (NUM_STORES),
    .PW         (PW)
  ) u_snoop (
    .clk          (clk),
    .rst          (rst),
    .vid_valid    (vid_valid),
    .vid_render   (vid_render),
    .vid_addr     (vid_addr),
    .vid_mem_data (vid_mem_data),
    .mode         (mode),
    .ext_en       (ext_attr_en),
    .store_q      (store_q),
    .rd_offset    (rd_offset),
    .vid_rvalid   (vid_rvalid),
    .vid_rdata    (vid_rdata)
  );

  assert_reset_quiet_R1: assert property (@(posedge clk)
    rst |=> (!vid_rvalid && vid_rdata == '0 && mirror_mode == 2'd0 && !ext_attr_en && !wram_wr_en));

endmodule

// File: tb/test_exattr_top.sv
`timescale 1ns/1ps
module test_exattr_top;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cpu_we = 1'b0;
  logic [15:0] cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0;
  logic        vid_valid = 1'b0;
  logic        vid_render = 1'b0;
  logic [13:0] vid_addr = '0;
  logic [7:0]  vid_mem_data = '0;
  logic        vid_rvalid;
  logic [7:0]  vid_rdata;
  logic [1:0]  mirror_mode;
  logic        ext_attr_en;
  logic        wram_wr_en;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  exattr_top i_exattr_top (
    .clk          (clk),
    .rst          (rst),
    .cpu_we       (cpu_we),
    .cpu_addr     (cpu_addr),
    .cpu_wdata    (cpu_wdata),
    .vid_valid    (vid_valid),
    .vid_render   (vid_render),
    .vid_addr     (vid_addr),
    .vid_mem_data (vid_mem_data),
    .vid_rvalid   (vid_rvalid),
    .vid_rdata    (vid_rdata),
    .mirror_mode  (mirror_mode),
    .ext_attr_en  (ext_attr_en),
    .wram_wr_en   (wram_wr_en)
  );

  // Reference model built from the requirements.
  logic [1:0] m_store [2][1024];
  logic [1:0] m_mode = 2'd0;
  bit         m_ext  = 1'b0;
  bit         m_wram = 1'b0;
  logic [9:0] m_off  = '0;

  // Scoreboard.
  logic [7:0] exp_q [$];
  string      tag_q [$];

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic model_write(input logic [15:0] a, input logic [7:0] d);
    if (a[15:14] == 2'b11) m_store[a[10]][a[9:0]] = d[1:0];
    else if (a[15:14] == 2'b10 && a[3:0] == 4'hA) begin
      m_mode = d[1:0];
      m_ext  = d[2];
      m_wram = d[3];
    end
  endtask

  function automatic logic [7:0] predict(input logic [13:0] a, input logic [7:0] md, input bit rnd);
    bit   hi, attr;
    logic bank;
    hi   = (a >= 14'h2000);
    attr = (a[9:0] >= 10'h3C0);
    if (rnd && hi && attr && m_ext) begin
      case (m_mode)
        2'd0:    bank = a[10];
        2'd1:    bank = a[11];
        2'd2:    bank = 1'b0;
        default: bank = 1'b1;
      endcase
      return {4{m_store[bank][m_off]}};
    end
    return md;
  endfunction

  task automatic model_fetch(input logic [13:0] a, input bit rnd, input string tag);
    if (rnd && a >= 14'h2000 && a[9:0] < 10'h3C0) m_off = a[9:0];
  endtask

  task automatic cpu_write(input logic [15:0] a, input logic [7:0] d);
    cpu_we = 1'b1; cpu_addr = a; cpu_wdata = d;
    @(negedge clk);
    cpu_we = 1'b0;
    model_write(a, d);
  endtask

  task automatic fetch(input logic [13:0] a, input logic [7:0] md, input bit rnd, input string tag);
    exp_q.push_back(predict(a, md, rnd));
    tag_q.push_back(tag);
    vid_valid = 1'b1; vid_render = rnd; vid_addr = a; vid_mem_data = md;
    @(negedge clk);
    vid_valid = 1'b0;
    model_fetch(a, rnd, tag);
  endtask

  // CPU write and video fetch in the same clock; prediction uses the old model.
  task automatic write_and_fetch(input logic [15:0] wa, input logic [7:0] wd,
                                 input logic [13:0] fa, input logic [7:0] md, input string tag);
    exp_q.push_back(predict(fa, md, 1'b1));
    tag_q.push_back(tag);
    cpu_we = 1'b1; cpu_addr = wa; cpu_wdata = wd;
    vid_valid = 1'b1; vid_render = 1'b1; vid_addr = fa; vid_mem_data = md;
    @(negedge clk);
    cpu_we = 1'b0; vid_valid = 1'b0;
    model_write(wa, wd);
    model_fetch(fa, 1'b1, tag);
  endtask

  task automatic check_ctrl(input string tag);
    check({mirror_mode, ext_attr_en, wram_wr_en} == {m_mode, m_ext, m_wram}, tag,
          {mirror_mode, ext_attr_en, wram_wr_en}, {m_mode, m_ext, m_wram});
  endtask

  // Monitor: compare each answer with the oldest prediction.
  always @(negedge clk) begin
    if (!rst && vid_rvalid) begin
      if (exp_q.size() == 0) check(1'b0, "R5 answer without fetch", vid_rdata, 0);
      else begin
        logic [7:0] e;
        string      t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(vid_rdata == e, t, vid_rdata, e);
      end
    end
  end

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    // R1: reset state
    check(vid_rvalid == 1'b0, "R1 rvalid", vid_rvalid, 0);
    check(vid_rdata == 8'h00, "R1 rdata", vid_rdata, 0);
    check(mirror_mode == 2'd0, "R1 mirror", mirror_mode, 0);
    check(ext_attr_en == 1'b0, "R1 ext enable", ext_attr_en, 0);
    check(wram_wr_en == 1'b0, "R1 wram enable", wram_wr_en, 0);
    rst = 1'b0;
    @(negedge clk);

    // R2: control register and its address mirrors
    cpu_write(16'h800A, 8'h0C); check_ctrl("R2 ctrl load");
    cpu_write(16'h9FFA, 8'h07); check_ctrl("R2 ctrl mirror address");
    cpu_write(16'h800B, 8'hF0); check_ctrl("R2 other register ignored");
    cpu_write(16'hC00A, 8'h00); check_ctrl("R2 store write ignored");

    // R3: fill stores, including mirrored window addresses
    cpu_write(16'hC000, 8'h01);
    cpu_write(16'hC400, 8'h02);
    cpu_write(16'hC005, 8'hFE);
    cpu_write(16'hC405, 8'h01);
    cpu_write(16'hFC12, 8'h02);
    cpu_write(16'hE812, 8'h03);
    cpu_write(16'h800A, 8'h06);

    fetch(14'h23C0, 8'h11, 1'b1, "R4 offset zero after reset");
    fetch(14'h2005, 8'h3A, 1'b1, "R7 name-table passes");
    fetch(14'h23C1, 8'h99, 1'b1, "R5 replicated palette");
    fetch(14'h2012, 8'h44, 1'b0, "R7 non-render name-table");
    fetch(14'h23C2, 8'h00, 1'b0, "R7 non-render attribute");
    fetch(14'h27C3, 8'h77, 1'b1, "R4 offset held");
    fetch(14'h0123, 8'h5C, 1'b1, "R7 low address passes");
    fetch(14'h23C0, 8'h00, 1'b1, "R4 offset held after low fetch");
    fetch(14'h2C12, 8'h1E, 1'b1, "R7 name-table passes");

    // R6: store selection per mirroring mode
    cpu_write(16'h800A, 8'h04);
    fetch(14'h27C0, 8'h00, 1'b1, "R6 vertical bit10 set");
    fetch(14'h2BC0, 8'h00, 1'b1, "R6 vertical bit10 clear");
    cpu_write(16'h800A, 8'h05);
    fetch(14'h27C0, 8'h00, 1'b1, "R6 horizontal bit11 clear");
    fetch(14'h2BC0, 8'h00, 1'b1, "R6 horizontal bit11 set");
    fetch(14'h2FC0, 8'h00, 1'b1, "R6 horizontal both bits");
    cpu_write(16'h800A, 8'h07);
    fetch(14'h23C0, 8'h00, 1'b1, "R6 R3 single B mirrored write");

    // R7: feature disabled
    cpu_write(16'h800A, 8'h03);
    fetch(14'h23C0, 8'h6B, 1'b1, "R7 disabled passes");
    cpu_write(16'h800A, 8'h06);
    fetch(14'h23C0, 8'h00, 1'b1, "R6 single A");

    // R8: store write and attribute fetch in the same clock
    write_and_fetch(16'hC012, 8'h01, 14'h23C0, 8'h00, "R8 old entry returned");
    fetch(14'h23C0, 8'h00, 1'b1, "R8 new entry visible");

    // R9: control write and attribute fetch in the same clock
    write_and_fetch(16'h800A, 8'h00, 14'h27C0, 8'h21, "R9 old settings used");
    fetch(14'h27C0, 8'h21, 1'b1, "R9 new settings used");
    check_ctrl("R9 ctrl after collision");

    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R5 all fetches answered", exp_q.size(), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule